// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block is the pin-facing front end for eight external interrupt inputs and one non-maskable interrupt input. Every pin first passes through a multi-flop synchronizer. Each of the eight inputs then goes through its own detector, and a two-bit sense mode chooses what that detector reacts to. The selected edge sets a sticky request bit, which software clears through a small 16-bit register bus. One request line per input goes to a downstream interrupt controller. Prioritising, vectoring and masking belong to that downstream controller.

The non-maskable input has its own sticky request flag and a one-bit edge polarity choice. The live synchronized level of that pin is visible through the bus.

In low-level mode a request line needs no software action. It follows the synchronized pin, asserted while the pin is low, and is not latched.

Top module: `extint_sense_ctrl`

## Requirements
- R1: The sense register sits at byte address 2. It holds a two-bit mode for each input n in bits 2n+1:2n, with the encoding 0 = low level, 1 = falling edge, 2 = rising edge, 3 = either edge. All 16 bits are written together and read back unchanged.
- R2: Every pin passes through a two-flop synchronizer. An edge is a difference between two successive synchronized samples. A pin change first sampled at clock edge k sets its request bit at edge k+2. In low-level mode the line changes at edge k+1.
- R3: The request register sits at byte address 4, with bit n belonging to input n. In an edge mode, the selected edge on input n sets bit n, and irq_req_o[n] equals that bit.
- R4: In low-level mode (0), irq_req_o[n] is the inverse of the synchronized pin, with no latching. The request bit is never set while the input is in this mode.
- R5: In a write to the request register, a 0 in bit n clears request bit n and a 1 leaves it unchanged. Bits 15:8 of this register read 0.
- R6: An edge detected in the same cycle that a write clears the bit leaves the bit set.
- R7: The NMI control register sits at byte address 0. Bit 15 reads the synchronized NMI pin level and ignores writes. Bit 8 is a read/write edge select, 0 = falling and 1 = rising. All other bits read 0 except bit 1.
- R8: NMI control bit 1 is a request flag. The selected NMI edge sets it. Writing 0 to it clears it, and writing 1 leaves it unchanged. An edge in the cycle of a clear wins. nmi_req_o equals the flag.
- R9: After reset, every sense field, every request bit, the NMI edge select and the NMI flag are 0.
- R10: Reads from any other byte address return 0. Writes to any other address change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_i | input | 8 | External interrupt pins, asynchronous |
| nmi_pin_i | input | 1 | Non-maskable interrupt pin, asynchronous |
| bus_addr_i | input | 3 | Register byte address |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i, combinational |
| irq_req_o | output | 8 | Request line per input to the downstream controller |
| nmi_req_o | output | 1 | NMI request to the downstream controller |

## Verification
The case that needs care is a software clear of a request bit that lands on the same clock edge as a new edge on that pin. The bench provokes it for an IRQ input and for the NMI input. It drives the pin change, counts two synchronizer edges, and then issues the clearing write so that the write and the detected edge meet at one clock edge. The bit must read back as set afterwards. A behavioural model of the pin history and the registers is compared on every clock while random pin activity and random clearing writes run, so such collisions also occur unplanned and are judged the same way.

// File: rtl/extint_pkg.sv
package extint_pkg;
   typedef enum logic [1:0] {
      SNS_LOW  = 2'd0,
      SNS_FALL = 2'd1,
      SNS_RISE = 2'd2,
      SNS_BOTH = 2'd3
   } sense_e;

   localparam int unsigned OFS_NMI   = 0;
   localparam int unsigned OFS_SENSE = 2;
   localparam int unsigned OFS_REQ   = 4;

   localparam int unsigned NMI_LVL_BIT  = 15;
   localparam int unsigned NMI_SEL_BIT  = 8;
   localparam int unsigned NMI_FLAG_BIT = 1;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
   parameter int unsigned WIDTH   = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("extint_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= {WIDTH{RST_VAL}};
               else        chain[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= {WIDTH{RST_VAL}};
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/extint_sense_cell.sv
module extint_sense_cell
   import extint_pkg::*;
#(
   parameter logic IDLE_VAL = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sync_i,
   input  logic [1:0] mode_i,
   input  logic       clr_i,
   output logic       req_o,
   output logic       line_o
);
   logic prev_q;
   logic req_q;
   logic rise, fall, hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE_VAL;
      else        prev_q <= sync_i;
   end

   assign rise = sync_i & ~prev_q;
   assign fall = ~sync_i & prev_q;

   always_comb begin
      case (mode_i)
         SNS_FALL: hit = fall;
         SNS_RISE: hit = rise;
         SNS_BOTH: hit = rise | fall;
         default:  hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     req_q <= 1'b0;
      else if (hit)   req_q <= 1'b1;
      else if (clr_i) req_q <= 1'b0;
   end

   assign req_o  = req_q;
   assign line_o = (mode_i == SNS_LOW) ? ~sync_i : req_q;

   AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> req_q); // R3
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && clr_i) |=> req_q); // R6
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && clr_i) |=> !req_q); // R5
   AST_LEVEL_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == SNS_LOW && !req_q) |=> !req_q); // R4
endmodule

// File: rtl/extint_sense_ctrl.sv
module extint_sense_ctrl
   import extint_pkg::*;
#(
   parameter int unsigned N_IRQ       = 8,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic        PIN_IDLE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_IRQ-1:0]  irq_pin_i,
   input  logic              nmi_pin_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_we_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic [N_IRQ-1:0]  irq_req_o,
   output logic              nmi_req_o
);
   localparam int unsigned SENSE_W = 2 * N_IRQ;
   localparam int unsigned PIN_W   = N_IRQ + 1;

   generate
      if (SENSE_W > DATA_W) begin : g_bad_width
         $error("extint_sense_ctrl: sense fields do not fit the data width");
      end
      if (DATA_W <= NMI_LVL_BIT) begin : g_bad_data
         $error("extint_sense_ctrl: data width too small for NMI control");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("extint_sense_ctrl: address too narrow for register map");
      end
   endgenerate

   logic [PIN_W-1:0]   pins_sync;
   logic [N_IRQ-1:0]   irq_sync;
   logic               nmi_sync;
   logic [SENSE_W-1:0] sense_q;
   logic               nmi_sel_q;
   logic [N_IRQ-1:0]   req_bits;
   logic [N_IRQ-1:0]   req_clr;
   logic               nmi_flag;
   logic               wr_nmi, wr_sense, wr_req;

   extint_sync #(
      .WIDTH   (PIN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({nmi_pin_i, irq_pin_i}),
      .q_o   (pins_sync)
   );

   assign irq_sync = pins_sync[N_IRQ-1:0];
   assign nmi_sync = pins_sync[N_IRQ];

   assign wr_nmi   = bus_we_i && (bus_addr_i == ADDR_W'(OFS_NMI));
   assign wr_sense = bus_we_i && (bus_addr_i == ADDR_W'(OFS_SENSE));
   assign wr_req   = bus_we_i && (bus_addr_i == ADDR_W'(OFS_REQ));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q   <= '0;
         nmi_sel_q <= 1'b0;
      end else begin
         if (wr_sense) sense_q   <= bus_wdata_i[SENSE_W-1:0];
         if (wr_nmi)   nmi_sel_q <= bus_wdata_i[NMI_SEL_BIT];
      end
   end

   generate
      for (genvar n = 0; n < N_IRQ; n++) begin : g_irq
         assign req_clr[n] = wr_req && !bus_wdata_i[n];
         extint_sense_cell #(.IDLE_VAL(PIN_IDLE)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .sync_i (irq_sync[n]),
            .mode_i (sense_q[2*n +: 2]),
            .clr_i  (req_clr[n]),
            .req_o  (req_bits[n]),
            .line_o (irq_req_o[n])
         );
      end
   endgenerate

   logic nmi_line_unused;
   extint_sense_cell #(.IDLE_VAL(PIN_IDLE)) u_nmi_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .sync_i (nmi_sync),
      .mode_i ({nmi_sel_q, ~nmi_sel_q}),
      .clr_i  (wr_nmi && !bus_wdata_i[NMI_FLAG_BIT]),
      .req_o  (nmi_flag),
      .line_o (nmi_line_unused)
   );

   assign nmi_req_o = nmi_flag;

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == ADDR_W'(OFS_NMI)) begin
         bus_rdata_o[NMI_LVL_BIT]  = nmi_sync;
         bus_rdata_o[NMI_SEL_BIT]  = nmi_sel_q;
         bus_rdata_o[NMI_FLAG_BIT] = nmi_flag;
      end else if (bus_addr_i == ADDR_W'(OFS_SENSE)) begin
         bus_rdata_o[SENSE_W-1:0] = sense_q;
      end else if (bus_addr_i == ADDR_W'(OFS_REQ)) begin
         bus_rdata_o[N_IRQ-1:0] = req_bits;
      end
   end

   AST_SENSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_sense |=> $stable(sense_q)); // R1
   AST_NMI_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_nmi |=> $stable(nmi_sel_q)); // R7
   AST_NMI_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_flag && !bus_we_i && $stable(nmi_sync)) |=> nmi_flag); // R8
endmodule

// File: tb/extint_sense_ctrl_test.sv
module extint_sense_ctrl_test;
   localparam int STG = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  irq_pin = 8'hFF;
   logic        nmi_pin = 1'b1;
   logic [2:0]  bus_addr = 3'd0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = 16'h0;
   logic [15:0] bus_rdata;
   logic [7:0]  irq_req;
   logic        nmi_req;

   int errors = 0;
   int checks = 0;
   bit model_on = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   extint_sense_ctrl #(.SYNC_STAGES(STG)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_pin_i   (irq_pin),
      .nmi_pin_i   (nmi_pin),
      .bus_addr_i  (bus_addr),
      .bus_we_i    (bus_we),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .irq_req_o   (irq_req),
      .nmi_req_o   (nmi_req)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [8:0]  hist [$];
   logic [15:0] m_sense = '0;
   logic [7:0]  m_req = '0;
   logic        m_nsel = 1'b0;
   logic        m_nflag = 1'b0;

   function automatic bit edge_hit(input logic [1:0] mode, input logic cur, input logic old);
      case (mode)
         2'd1: return (!cur && old);
         2'd2: return (cur && !old);
         2'd3: return (cur != old);
         default: return 1'b0;
      endcase
   endfunction

   initial begin
      for (int i = 0; i <= STG; i++) hist.push_back(9'h1FF);
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         hist.delete();
         for (int i = 0; i <= STG; i++) hist.push_back(9'h1FF);
         m_sense = '0; m_req = '0; m_nsel = 1'b0; m_nflag = 1'b0;
      end else begin
         logic [8:0] s_old, p_old;
         logic [1:0] nmode;
         s_old = hist[STG-1];
         p_old = hist[STG];
         for (int n = 0; n < 8; n++) begin
            if (edge_hit(m_sense[2*n +: 2], s_old[n], p_old[n])) m_req[n] = 1'b1;
            else if (bus_we && bus_addr == 3'd4 && !bus_wdata[n]) m_req[n] = 1'b0;
         end
         nmode = m_nsel ? 2'd2 : 2'd1;
         if (edge_hit(nmode, s_old[8], p_old[8])) m_nflag = 1'b1;
         else if (bus_we && bus_addr == 3'd0 && !bus_wdata[1]) m_nflag = 1'b0;
         if (bus_we && bus_addr == 3'd2) m_sense = bus_wdata;
         if (bus_we && bus_addr == 3'd0) m_nsel = bus_wdata[8];
         hist.push_front({nmi_pin, irq_pin});
         void'(hist.pop_back());
      end
   end

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      #5;
      if (model_on && !done) begin
         logic [8:0]  s_now;
         logic [7:0]  e_irq;
         logic [15:0] e_rd;
         s_now = hist[STG-1];
         for (int n = 0; n < 8; n++)
            e_irq[n] = (m_sense[2*n +: 2] == 2'd0) ? !s_now[n] : m_req[n];
         case (bus_addr)
            3'd0: e_rd = {s_now[8], 6'b0, m_nsel, 6'b0, m_nflag, 1'b0};
            3'd2: e_rd = m_sense;
            3'd4: e_rd = {8'h00, m_req};
            default: e_rd = 16'h0;
         endcase
         check(32'(irq_req), 32'(e_irq), "R2 R3 R4 model irq lines");
         check(32'(nmi_req), 32'(m_nflag), "R8 model nmi line");
         check(32'(bus_rdata), 32'(e_rd), "R1 R5 R7 R10 model read data");
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic expect_rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a;
      #5;
      check(32'(bus_rdata), 32'(exp), tag);
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog all requirements actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      model_on = 1'b1;

      // R9 reset state
      expect_rd(3'd0, 16'h8000, "R9 NMI control after reset");
      expect_rd(3'd2, 16'h0000, "R9 sense after reset");
      expect_rd(3'd4, 16'h0000, "R9 requests after reset");
      check(32'(irq_req), 32'h0, "R9 lines idle after reset");
      check(32'(nmi_req), 32'h0, "R9 nmi idle after reset");

      // R4 level mode follows pin, not latched
      @(negedge clk); irq_pin[3] = 1'b0;
      @(negedge clk); #5;
      check(32'(irq_req[3]), 32'h0, "R2 level line before second edge");
      @(negedge clk); #5;
      check(32'(irq_req[3]), 32'h1, "R4 level line asserted while low");
      expect_rd(3'd4, 16'h0000, "R4 level mode sets no request bit");
      @(negedge clk); irq_pin[3] = 1'b1;
      settle(); #5;
      check(32'(irq_req[3]), 32'h0, "R4 level line released");

      // R1 sense programming: irq0 low, irq1 fall, irq2 rise, irq3 both, repeated
      bus_wr(3'd2, 16'hE4E4);
      expect_rd(3'd2, 16'hE4E4, "R1 sense read back");

      // R3 falling edge latches on irq1
      @(negedge clk); irq_pin[1] = 1'b0;
      settle();
      expect_rd(3'd4, 16'h0002, "R3 falling edge sets bit 1");
      @(negedge clk); irq_pin[1] = 1'b1;
      settle(); #5;
      check(32'(irq_req[1]), 32'h1, "R3 request stays latched");

      // R5 write-1 keeps, write-0 clears
      bus_wr(3'd4, 16'hFFFF);
      expect_rd(3'd4, 16'h0002, "R5 write one keeps bit");
      bus_wr(3'd4, 16'hFFFD);
      expect_rd(3'd4, 16'h0000, "R5 write zero clears bit");

      // R2 timing on irq2 (rising)
      @(negedge clk); irq_pin[2] = 1'b0;
      settle();
      expect_rd(3'd4, 16'h0000, "R3 falling ignored in rising mode");
      irq_pin[2] = 1'b1;
      @(negedge clk); #5;
      check(32'(irq_req[2]), 32'h0, "R2 not set after one edge");
      @(negedge clk); #5;
      check(32'(irq_req[2]), 32'h0, "R2 not set after two edges");
      @(negedge clk); #5;
      check(32'(irq_req[2]), 32'h1, "R2 set at third edge");
      bus_wr(3'd4, 16'h00FB);

      // R6 set wins over clear on irq3 (both edges)
      @(negedge clk); irq_pin[3] = 1'b0;
      settle();
      expect_rd(3'd4, 16'h0008, "R3 both-edge mode sets bit 3");
      irq_pin[3] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_addr = 3'd4; bus_wdata = 16'hFFF7; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      #5;
      check(32'(irq_req[3]), 32'h1, "R6 edge beats clear");
      bus_wr(3'd4, 16'hFFF7);
      expect_rd(3'd4, 16'h0000, "R5 later clear works");

      // R7 / R8 NMI
      @(negedge clk); nmi_pin = 1'b0;
      settle();
      expect_rd(3'd0, 16'h0002, "R8 falling NMI sets flag, R7 level low");
      check(32'(nmi_req), 32'h1, "R8 nmi line");
      bus_wr(3'd0, 16'h0002);
      expect_rd(3'd0, 16'h0002, "R8 write one keeps flag");
      bus_wr(3'd0, 16'h0100);
      expect_rd(3'd0, 16'h0100, "R8 write zero clears, R7 select set");
      @(negedge clk); nmi_pin = 1'b1;
      settle();
      expect_rd(3'd0, 16'h8102, "R8 rising NMI sets flag, R7 level high");
      bus_wr(3'd0, 16'h0100);
      expect_rd(3'd0, 16'h8100, "R7 level bit ignores write");
      // R8 set wins on NMI
      @(negedge clk); nmi_pin = 1'b0;
      settle();
      nmi_pin = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_addr = 3'd0; bus_wdata = 16'h0100; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      #5;
      check(32'(nmi_req), 32'h1, "R8 NMI edge beats clear");

      // R10 unused address
      bus_wr(3'd6, 16'h0000);
      expect_rd(3'd6, 16'h0000, "R10 unused address reads zero");
      expect_rd(3'd2, 16'hE4E4, "R10 unused write leaves sense");
      expect_rd(3'd0, 16'h8102, "R10 unused write leaves NMI control");

      // random phase, judged by the model every clock
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         bus_we = 1'b0;
         if ($urandom_range(0, 3) == 0) irq_pin = irq_pin ^ 8'($urandom_range(0, 255));
         if ($urandom_range(0, 7) == 0) nmi_pin = ~nmi_pin;
         bus_addr = 3'($urandom_range(0, 7));
         if ($urandom_range(0, 5) == 0) begin
            bus_we = 1'b1;
            bus_wdata = 16'($urandom_range(0, 65535));
            if (bus_addr == 3'd4 && $urandom_range(0, 1) == 0) bus_wdata = 16'hFFFF;
         end
      end
      @(negedge clk);
      bus_we = 1'b0;
      repeat (3) @(negedge clk);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule